// File: doc/BRIEF.md
# Paged Address Translation Walker

This block turns an 18-bit virtual word address into a 19-bit physical address for a processor that has a user mode and an exec mode. Virtual pages are 1024 words, so the top 8 address bits name the page. Each reference picks one of three page-map base addresses. User references below the midpoint of the address space use the low user base, and user references at or above it use the high user base. Exec references in the upper half use the exec base. Exec references in the lower half bypass translation altogether.

A small direct-mapped translation cache holds 512-word half-page entries. A hit answers in the next cycle. A miss makes one read of the page-table word at base plus the page's index in the map. The walker stamps the current age value into both entries of that word and writes the word back to the same address. It then loads both half-page cache entries of the referenced page, checks the access code against the cycle type, and returns either a physical address or a fault with a reason code. An invalidate input clears the whole cache in one cycle.

Top module: `pw_walker`

## Requirements
- R1: For a user reference with address bit 17 clear, the table word is read from `base_ulo + va[16:11]`. With bit 17 set, it is read from `base_uhi + va[16:11]`. For an exec reference with bit 17 set, it is read from `base_xhi + va[16:11]`.
- R2: An exec reference with address bit 17 clear returns `{1'b0, va}` with no fault and no memory access, in the cycle after acceptance.
- R3: A 36-bit table word holds the even page (`va[10]`=0) in bits 35:18 and the odd page in bits 17:0. Each 18-bit entry carries the access code in bits 17:16, the age in bits 15:12, and the physical page number in bits 8:0. A granted reference returns `{ppn, va[9:0]}`.
- R4: A miss makes exactly one table read followed by one write of the same word to the same address. In the written word, bits 33:30 and 15:12 are replaced by `age_val`, and every other bit is unchanged.
- R5: Access codes are 0 none, 1 read-only, 2 read-write-first and 3 read-write. Cycle codes are 0 read, 1 write and 2 read-modify-write. Code 0 faults with reason 1. A write or read-modify-write faults with reason 2 on code 1 and reason 3 on code 2. Every other combination is granted with reason 0. A faulting response has a physical address of 0.
- R6: One refill loads both 512-word halves of the referenced page, so a reference to the other half then hits.
- R7: A cache hit answers in the cycle after acceptance and makes no memory access.
- R8: A one-cycle pulse on `inval` clears every cache entry, so the next mapped reference misses.
- R9: Cache entries are tagged with the mode. A user entry never answers an exec reference to the same address, and an exec entry never answers a user reference.
- R10: An entry whose reference faulted is still cached. A later permitted reference to it hits.
- R11: `req_ready` is low while a table walk is in progress, and each accepted request produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 18 | Virtual word address |
| req_user | input | 1 | 1 user mode, 0 exec mode |
| req_cyc | input | 2 | Cycle type: 0 read, 1 write, 2 read-modify-write |
| inval | input | 1 | Clear all translation cache entries |
| age_val | input | 4 | Age stamped into fetched table words |
| base_ulo | input | 19 | Page map base for low user half |
| base_uhi | input | 19 | Page map base for high user half |
| base_xhi | input | 19 | Page map base for high exec half |
| resp_valid | output | 1 | Response pulse |
| resp_pa | output | 19 | Physical address (0 on fault) |
| resp_fault | output | 1 | Reference denied |
| resp_reason | output | 2 | Fault reason code |
| mem_rd_en | output | 1 | Table word read request |
| mem_wr_en | output | 1 | Table word write-back request |
| mem_addr | output | 19 | Table word address |
| mem_wdata | output | 36 | Age-stamped table word |
| mem_rdata | input | 36 | Table word read data |
| mem_ack | input | 1 | Memory completes the current access |

## Verification
A stale or mis-tagged cache entry shows up at the ports as a response one cycle after acceptance with no table read. The expected behaviour there is three cycles and one read, so the fault appears on the very next request to that address. A wrong base choice or a wrong half selection appears at once as a wrong physical page number or a wrong access verdict. A bad age stamp leaves a wrong word in memory as soon as the walk completes. The bench therefore checks latency, read count, address and reason for every reference, and reads the table words back after each walk that matters.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int VA_W    = 18;
    localparam int PA_W    = 19;
    localparam int OFF_W   = 10;
    localparam int PPN_W   = 9;
    localparam int AGE_W   = 4;
    localparam int ENT_W   = 18;
    localparam int WORD_W  = 2 * ENT_W;
    localparam int MAPIX_W = 6;
    localparam int HPG_W   = VA_W - OFF_W + 1;

    typedef enum logic [1:0] {
        CYC_READ  = 2'd0,
        CYC_WRITE = 2'd1,
        CYC_RMW   = 2'd2
    } cyc_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_RWF  = 2'd2,
        ACC_RW   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        WHY_OK      = 2'd0,
        WHY_NOACC   = 2'd1,
        WHY_RDONLY  = 2'd2,
        WHY_RWFIRST = 2'd3
    } why_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE
    } walk_st_e;

    typedef struct packed {
        acc_e             acc;
        logic [AGE_W-1:0] age;
        logic [2:0]       spare;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic            user;
        cyc_e            cyc;
    } xreq_t;

    typedef struct packed {
        logic            fault;
        why_e            why;
        logic [PA_W-1:0] pa;
    } xresp_t;

    function automatic why_e judge(acc_e a, cyc_e c);
        why_e w;
        if (a == ACC_NONE)       w = WHY_NOACC;
        else if (c == CYC_READ)  w = WHY_OK;
        else if (a == ACC_RO)    w = WHY_RDONLY;
        else if (a == ACC_RWF)   w = WHY_RWFIRST;
        else                     w = WHY_OK;
        return w;
    endfunction

    function automatic xresp_t grade(acc_e a, logic [PPN_W-1:0] ppn,
                                     logic [OFF_W-1:0] off, cyc_e c);
        xresp_t r;
        r.why   = judge(a, c);
        r.fault = (r.why != WHY_OK);
        r.pa    = r.fault ? '0 : {ppn, off};
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] stamp(logic [WORD_W-1:0] w,
                                                logic [AGE_W-1:0] age);
        pte_t ev;
        pte_t od;
        ev     = pte_t'(w[WORD_W-1:ENT_W]);
        od     = pte_t'(w[ENT_W-1:0]);
        ev.age = age;
        od.age = age;
        return {ev, od};
    endfunction

    function automatic pte_t pick(logic [WORD_W-1:0] w, logic odd);
        return odd ? pte_t'(w[ENT_W-1:0]) : pte_t'(w[WORD_W-1:ENT_W]);
    endfunction

endpackage

// File: rtl/pw_base_sel.sv
module pw_base_sel
    import pw_pkg::*;
(
    input  logic [6:0]      va_hi,
    input  logic            user,
    input  logic [PA_W-1:0] base_ulo,
    input  logic [PA_W-1:0] base_uhi,
    input  logic [PA_W-1:0] base_xhi,
    output logic            mapped,
    output logic [PA_W-1:0] tbl_addr
);

    logic [PA_W-1:0] base;
    logic            upper;

    assign upper = va_hi[6];

    always_comb begin
        mapped = 1'b1;
        if (user) begin
            base = upper ? base_uhi : base_ulo;
        end else if (upper) begin
            base = base_xhi;
        end else begin
            base   = '0;
            mapped = 1'b0;
        end
        tbl_addr = base + PA_W'(va_hi[MAPIX_W-1:0]);
    end

endmodule

// File: rtl/pw_tcache.sv
module pw_tcache
    import pw_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [HPG_W-1:0] lk_hpg,
    input  logic             lk_user,
    output logic             lk_hit,
    output acc_e             lk_acc,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [HPG_W-1:0] fill_hpg,
    input  logic             fill_user,
    input  acc_e             fill_acc,
    input  logic [PPN_W-1:0] fill_ppn
);

    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = 1 + HPG_W - IDX_W;

    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];
    acc_e             acc_q [SETS];
    logic [PPN_W-1:0] ppn_q [SETS];

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] idx_even;
    logic [IDX_W-1:0] idx_odd;
    logic [TAG_W-1:0] fill_tag;
    logic [SETS-1:0]  wsel;

    assign lk_idx   = lk_hpg[IDX_W-1:0];
    assign lk_tag   = {lk_user, lk_hpg[HPG_W-1:IDX_W]};
    assign idx_even = fill_hpg[IDX_W-1:0] & ~IDX_W'(1);
    assign idx_odd  = fill_hpg[IDX_W-1:0] |  IDX_W'(1);
    assign fill_tag = {fill_user, fill_hpg[HPG_W-1:IDX_W]};

    for (genvar s = 0; s < SETS; s++) begin : g_wsel
        assign wsel[s] = fill_en &&
                         ((idx_even == IDX_W'(s)) || (idx_odd == IDX_W'(s)));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (wsel[s]) begin
                    valid_q[s] <= 1'b1;
                    tag_q[s]   <= fill_tag;
                    acc_q[s]   <= fill_acc;
                    ppn_q[s]   <= fill_ppn;
                end
            end
        end
    end

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_acc = acc_q[lk_idx];
    assign lk_ppn = ppn_q[lk_idx];

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R6
    pair_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush) |=>
            (valid_q[$past(idx_even)] && valid_q[$past(idx_odd)]));

endmodule

// File: rtl/pw_walker.sv
module pw_walker
    import pw_pkg::*;
#(
    parameter int SET_IDX_W = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [17:0] req_va,
    input  logic        req_user,
    input  logic [1:0]  req_cyc,
    input  logic        inval,
    input  logic [3:0]  age_val,
    input  logic [18:0] base_ulo,
    input  logic [18:0] base_uhi,
    input  logic [18:0] base_xhi,
    output logic        resp_valid,
    output logic [18:0] resp_pa,
    output logic        resp_fault,
    output logic [1:0]  resp_reason,
    output logic        mem_rd_en,
    output logic        mem_wr_en,
    output logic [18:0] mem_addr,
    output logic [35:0] mem_wdata,
    input  logic [35:0] mem_rdata,
    input  logic        mem_ack
);

    walk_st_e          st_q;
    xreq_t             held_q;
    logic [PA_W-1:0]   tbl_q;
    logic [WORD_W-1:0] word_q;
    xresp_t            resp_q;
    logic              resp_v_q;

    xreq_t           inreq;
    logic            mapped;
    logic [PA_W-1:0] tbl_addr;
    logic            hit;
    acc_e            hit_acc;
    logic [PPN_W-1:0] hit_ppn;
    pte_t            fetched;
    logic            fill_en;
    logic            accept;

    assign inreq   = '{va: req_va, user: req_user, cyc: cyc_e'(req_cyc)};
    assign accept  = (st_q == ST_IDLE) && req_valid;
    assign fetched = pick(word_q, held_q.va[OFF_W]);
    assign fill_en = (st_q == ST_STORE) && mem_ack;

    pw_base_sel u_sel (
        .va_hi    (req_va[VA_W-1:OFF_W+1]),
        .user     (req_user),
        .base_ulo (base_ulo),
        .base_uhi (base_uhi),
        .base_xhi (base_xhi),
        .mapped   (mapped),
        .tbl_addr (tbl_addr)
    );

    pw_tcache #(.IDX_W(SET_IDX_W)) u_tc (
        .clk       (clk),
        .rst       (rst),
        .flush     (inval),
        .lk_hpg    (req_va[VA_W-1:OFF_W-1]),
        .lk_user   (req_user),
        .lk_hit    (hit),
        .lk_acc    (hit_acc),
        .lk_ppn    (hit_ppn),
        .fill_en   (fill_en),
        .fill_hpg  (held_q.va[VA_W-1:OFF_W-1]),
        .fill_user (held_q.user),
        .fill_acc  (fetched.acc),
        .fill_ppn  (fetched.ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            held_q   <= '0;
            tbl_q    <= '0;
            word_q   <= '0;
            resp_q   <= '0;
            resp_v_q <= 1'b0;
        end else begin
            resp_v_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        held_q <= inreq;
                        tbl_q  <= tbl_addr;
                        if (!mapped) begin
                            resp_v_q <= 1'b1;
                            resp_q   <= '{fault: 1'b0, why: WHY_OK,
                                          pa: {1'b0, inreq.va}};
                        end else if (hit) begin
                            resp_v_q <= 1'b1;
                            resp_q   <= grade(hit_acc, hit_ppn,
                                              inreq.va[OFF_W-1:0], inreq.cyc);
                        end else begin
                            st_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        word_q <= stamp(mem_rdata, age_val);
                        st_q   <= ST_STORE;
                    end
                end
                ST_STORE: begin
                    if (mem_ack) begin
                        resp_v_q <= 1'b1;
                        resp_q   <= grade(fetched.acc, fetched.ppn,
                                          held_q.va[OFF_W-1:0], held_q.cyc);
                        st_q     <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (st_q == ST_IDLE);
    assign resp_valid  = resp_v_q;
    assign resp_pa     = resp_q.pa;
    assign resp_fault  = resp_q.fault;
    assign resp_reason = resp_q.why;
    assign mem_rd_en   = (st_q == ST_FETCH);
    assign mem_wr_en   = (st_q == ST_STORE);
    assign mem_addr    = tbl_q;
    assign mem_wdata   = word_q;

    // R7
    hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && mapped && hit) |=> (resp_valid && !mem_rd_en && !mem_wr_en));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !mapped) |=>
            (resp_valid && !resp_fault && resp_pa == {1'b0, $past(req_va)}));

    // R4
    store_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_en) |-> $past(mem_rd_en && mem_ack));

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    // R5
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_pa == '0 && resp_reason != 2'd0));

    // R11
    busy_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en) |-> (!req_ready && !resp_valid));

endmodule

// File: tb/tb_pw_walker.sv
module tb_pw_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_va = '0;
    logic        req_user = 1'b0;
    logic [1:0]  req_cyc = '0;
    logic        inval = 1'b0;
    logic [3:0]  age_val = 4'hA;
    logic [18:0] base_ulo = 19'd64;
    logic [18:0] base_uhi = 19'd128;
    logic [18:0] base_xhi = 19'd256;
    logic        resp_valid;
    logic [18:0] resp_pa;
    logic        resp_fault;
    logic [1:0]  resp_reason;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [18:0] mem_addr;
    logic [35:0] mem_wdata;
    logic [35:0] mem_rdata;
    logic        mem_ack;

    always #2 clk = ~clk;

    pw_walker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_user(req_user), .req_cyc(req_cyc),
        .inval(inval), .age_val(age_val), .base_ulo(base_ulo),
        .base_uhi(base_uhi), .base_xhi(base_xhi), .resp_valid(resp_valid),
        .resp_pa(resp_pa), .resp_fault(resp_fault), .resp_reason(resp_reason),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Zero-wait memory model with a poke port for table setup
    logic [35:0] mem [512];
    logic        poke_en = 1'b0;
    logic [8:0]  poke_addr = '0;
    logic [35:0] poke_data = '0;
    int          rd_count = 0;
    int          cyc_cnt = 0;

    assign mem_ack   = mem_rd_en | mem_wr_en;
    assign mem_rdata = mem[mem_addr[8:0]];

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (mem_rd_en) rd_count <= rd_count + 1;
        if (rst) begin
            for (int i = 0; i < 512; i++) mem[i] <= '0;
        end else if (mem_wr_en) begin
            mem[mem_addr[8:0]] <= mem_wdata;
        end else if (poke_en) begin
            mem[poke_addr] <= poke_data;
        end
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    typedef struct {
        logic [18:0] pa;
        logic        fault;
        logic [1:0]  why;
        int          reads;
        int          lat;
        int          acc_cyc;
        int          rd_base;
        string       rq;
    } exp_t;

    exp_t sb[$];

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11", "unexpected response", 64'(resp_pa), 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(resp_pa == e.pa, e.rq, "pa", 64'(resp_pa), 64'(e.pa));
                chk(resp_fault == e.fault && resp_reason == e.why, e.rq,
                    "fault/reason", 64'({resp_fault, resp_reason}),
                    64'({e.fault, e.why}));
                chk((rd_count - e.rd_base) == e.reads, e.rq, "table reads",
                    64'(rd_count - e.rd_base), 64'(e.reads));
                chk((cyc_cnt - e.acc_cyc) == e.lat, e.rq, "latency",
                    64'(cyc_cnt - e.acc_cyc), 64'(e.lat));
            end
        end
    end

    function automatic logic [17:0] ent(input logic [1:0] acc,
                                        input logic [8:0] ppn,
                                        input logic [3:0] age);
        return {acc, age, 3'b101, ppn};
    endfunction

    function automatic logic [17:0] mkva(input logic hi, input logic [6:0] pg,
                                         input logic [9:0] off);
        return {hi, pg, off};
    endfunction

    task automatic poke(input logic [8:0] a, input logic [35:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic xact(input logic [17:0] va, input logic user,
                        input logic [1:0] cyc, input logic ef,
                        input logic [1:0] ew, input logic [18:0] epa,
                        input int ereads, input int elat, input string rq);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = va; req_user = user; req_cyc = cyc;
        e.pa = epa; e.fault = ef; e.why = ew; e.reads = ereads; e.lat = elat;
        e.acc_cyc = cyc_cnt; e.rd_base = rd_count; e.rq = rq;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (elat > 1) chk(req_ready == 1'b0, "R11", "ready during walk",
                          64'(req_ready), 64'h0);
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic flush();
        @(negedge clk);
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R11", "reset resp_valid", 64'(resp_valid), 64'h0);
        chk(req_ready == 1'b1, "R11", "reset ready", 64'(req_ready), 64'h1);
        chk(!mem_rd_en && !mem_wr_en, "R4", "reset mem idle",
            64'({mem_rd_en, mem_wr_en}), 64'h0);

        poke(9'd65,  {ent(2'd3, 9'h1A5, 4'h0), ent(2'd1, 9'h033, 4'h0)});
        poke(9'd129, {ent(2'd2, 9'h0C4, 4'h0), ent(2'd3, 9'h0D0, 4'h0)});
        poke(9'd257, {ent(2'd3, 9'h111, 4'h0), ent(2'd0, 9'h000, 4'h0)});
        poke(9'd260, {ent(2'd3, 9'h0AB, 4'h0), ent(2'd0, 9'h1FF, 4'h0)});

        // R2: exec low half bypasses translation
        xact(mkva(0, 7'd5, 10'h123), 1'b0, 2'd0, 1'b0, 2'd0,
             {1'b0, mkva(0, 7'd5, 10'h123)}, 0, 1, "R2");
        // R1 R3: user low half, even page, miss
        xact(mkva(0, 7'd2, 10'h155), 1'b1, 2'd0, 1'b0, 2'd0,
             {9'h1A5, 10'h155}, 1, 3, "R1");
        @(negedge clk);
        chk(mem[65] == {ent(2'd3, 9'h1A5, 4'hA), ent(2'd1, 9'h033, 4'hA)},
            "R4", "age write-back", 64'(mem[65]),
            64'({ent(2'd3, 9'h1A5, 4'hA), ent(2'd1, 9'h033, 4'hA)}));
        // R6: other half of same page hits
        xact(mkva(0, 7'd2, 10'h3AA), 1'b1, 2'd0, 1'b0, 2'd0,
             {9'h1A5, 10'h3AA}, 0, 1, "R6");
        // R7: hit on write to read-write page
        xact(mkva(0, 7'd2, 10'h155), 1'b1, 2'd1, 1'b0, 2'd0,
             {9'h1A5, 10'h155}, 0, 1, "R7");
        // R5: write to read-only odd page faults with reason 2
        xact(mkva(0, 7'd3, 10'h0F0), 1'b1, 2'd1, 1'b1, 2'd2, 19'h0, 1, 3, "R5");
        // R10 R3: read of the faulted entry hits, odd half-word
        xact(mkva(0, 7'd3, 10'h0F0), 1'b1, 2'd0, 1'b0, 2'd0,
             {9'h033, 10'h0F0}, 0, 1, "R10");
        // R1: user high half uses the second base
        xact(mkva(1, 7'd2, 10'h010), 1'b1, 2'd0, 1'b0, 2'd0,
             {9'h0C4, 10'h010}, 1, 3, "R1");
        // R5: write to read-write-first faults with reason 3
        xact(mkva(1, 7'd2, 10'h010), 1'b1, 2'd1, 1'b1, 2'd3, 19'h0, 0, 1, "R5");
        // R9: same address in exec mode misses and uses third base
        xact(mkva(1, 7'd2, 10'h010), 1'b0, 2'd0, 1'b0, 2'd0,
             {9'h111, 10'h010}, 1, 3, "R9");
        xact(mkva(1, 7'd2, 10'h010), 1'b1, 2'd0, 1'b0, 2'd0,
             {9'h0C4, 10'h010}, 1, 3, "R9");
        // R5: no-access entry faults with reason 1 on read-modify-write
        xact(mkva(1, 7'd9, 10'h200), 1'b0, 2'd2, 1'b1, 2'd1, 19'h0, 1, 3, "R5");
        // R5: read-modify-write granted on read-write page
        xact(mkva(1, 7'd8, 10'h001), 1'b0, 2'd2, 1'b0, 2'd0,
             {9'h0AB, 10'h001}, 1, 3, "R5");
        xact(mkva(1, 7'd8, 10'h201), 1'b0, 2'd0, 1'b0, 2'd0,
             {9'h0AB, 10'h201}, 0, 1, "R7");
        // R8: invalidate forces a new walk; new age value stamped
        age_val = 4'h5;
        flush();
        xact(mkva(1, 7'd8, 10'h201), 1'b0, 2'd0, 1'b0, 2'd0,
             {9'h0AB, 10'h201}, 1, 3, "R8");
        @(negedge clk);
        chk(mem[260] == {ent(2'd3, 9'h0AB, 4'h5), ent(2'd0, 9'h1FF, 4'h5)},
            "R4", "age write-back after flush", 64'(mem[260]),
            64'({ent(2'd3, 9'h0AB, 4'h5), ent(2'd0, 9'h1FF, 4'h5)}));
        // R2: top of exec low half
        xact(mkva(0, 7'h3F, 10'h3FF), 1'b0, 2'd1, 1'b0, 2'd0,
             {1'b0, mkva(0, 7'h3F, 10'h3FF)}, 0, 1, "R2");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule